// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction into the 32-bit base-ISA word that performs the same operation. An execution pipeline can then run both instruction sets through a single decoder. The block takes a 32-bit fetch word holding two halfwords. An ordering input picks the halfword that is the current instruction. The 5-bit group field in bits [15:11] of that halfword chooses a format. Each format starts from a base opcode and moves the register, immediate and mask fields of the halfword into their full-width positions.

The block also returns a 2-bit status with each word:

| Status | Code | Meaning |
|---|---|---|
| translated | `2'b00` | the output word is the expanded instruction |
| branch | `2'b01` | the halfword is a branch, handed to a separate unit |
| undefined | `2'b10` | the halfword has no defined meaning |

For branch and undefined halfwords the output word is the fixed filler `32'hDEADC0DE`, so downstream logic can tell that nothing was translated. By default the result is registered with a valid flag. A parameter removes the register and leaves a purely combinational path.

Top module: `cx_expand`

## Requirements
- R1: With `hi_first` = 1 the current halfword is `fetch_word[31:16]`; with `hi_first` = 0 it is `fetch_word[15:0]`.
- R2: Groups 0 to 2 (immediate shift) give `0xE1B00000` with halfword [12:11] at [6:5], [10:6] at [11:7], [5:3] at [3:0] and [2:0] at [14:12].
- R3: Group 3 (three-operand add/sub) chooses base `E0900000`, `E0500000`, `E2900000` or `E2500000` by halfword [10:9], then places [8:6] at [2:0], [5:3] at [18:16] and [2:0] at [14:12].
- R4: Groups 4 to 7 (8-bit immediate) choose base `E3B00000`, `E3500000`, `E2900000` or `E2500000` by [12:11]. Register [10:8] goes to both [18:16] and [14:12], and the immediate goes to [7:0].
- R5: Group 8 with bit 10 clear picks one of 16 register ALU operations by [9:6], using one of four operand placements: plain, shift by register, negate (`E2700000`) and multiply (`E0100090`, destination at [19:16] and [11:8]).
- R6: Group 8 with bit 10 set widens both registers to 4 bits. Bit 7 is the destination top bit and bit 6 is the source top bit. Sub-ops 1-3, 5-7 and 9-B give add, compare and move. Sub-ops C-D give `E12FFF10` with [6:3] at [3:0]. Sub-ops 0, 4, 8, E and F are undefined.
- R7: Group 9 gives the PC-relative load `E59F0000` with the offset scaled by 4. Groups 10 and 11 give the register-offset transfers, chosen by bit 9 and [11:10].
- R8: Groups 12 to 15 scale the 5-bit offset by 4 when bit 12 = 0 (word) and leave it unscaled when bit 12 = 1 (byte). Groups 16 and 17 split the halfword offset, doubled, into [3:0] and [11:8].
- R9: Groups 18 and 19 give SP-relative load/store with the offset scaled by 4. Groups 20 and 21 give `E28F0F00` (bit 11 = 0) or `E28D0F00` (bit 11 = 1) with the immediate unshifted at [7:0].
- R10: In groups 22 and 23:
  - bits [11:8] = 0 adjust SP by the 7-bit immediate (bit 7 = 1 subtracts);
  - bits [11:8] = E are undefined;
  - any other value is a push/pop, with the base chosen by {bit 11, bit 8}.

  Groups 24 and 25 give the multiple transfer with base register [10:8] at [18:16].
- R11: Groups 26 and 27 with [11:8] = F give `EF000000` ORed with the 8-bit number. The number `0x18` is instead placed at [23:16].
- R12: The remaining halfwords of groups 26 and 27 report branch status, except condition `E`, which is undefined. Groups 28, 30 and 31 are branch and group 29 is undefined. Every non-translated status outputs `DEADC0DE`, and code `2'b11` never appears.
- R13: With the output register on, `in_valid` is reflected on `out_valid` one cycle later. When `in_valid` is low the word and status hold. Reset gives `out_valid` = 0, the filler word and undefined status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch word is valid this cycle |
| fetch_word | input | 32 | Two halfwords from instruction fetch |
| hi_first | input | 1 | 1: upper halfword is current; 0: lower halfword |
| out_valid | output | 1 | Output word and status are valid |
| out_word | output | 32 | Expanded 32-bit instruction or filler |
| out_status | output | 2 | 00 translated, 01 branch, 10 undefined |

## Verification
Hand-picked halfwords from every format are checked against constant expected words. Each one uses register numbers that differ between fields, so a swapped or mis-shifted field shows up. The multiply, negate and shift-by-register entries check that the ALU group applies each of its four operand placements. The word and byte offsets at equal field values tell the two scalings apart. The two `hi_first` settings are tried on one fetch word whose halves differ, which catches a reversed lane. Finally, every one of the 65,536 halfwords is swept, with the lane alternating, and compared with a behavioural model. This covers the undefined sub-op and condition holes at the format edges.

// File: rtl/cx_pkg.sv
package cx_pkg;

    localparam int CX_FETCH_W = 32;
    localparam int CX_HALF_W  = CX_FETCH_W / 2;
    localparam int CX_GRP_W   = 5;

    localparam logic [CX_FETCH_W-1:0] CX_FILLER = 32'hDEADC0DE;

    typedef enum logic [1:0] {
        CX_OK     = 2'b00,
        CX_BRANCH = 2'b01,
        CX_UNDEF  = 2'b10
    } cx_status_e;

    typedef enum logic [1:0] {
        ALU_PLAIN,
        ALU_SHIFT,
        ALU_NEG,
        ALU_MUL
    } cx_alu_style_e;

    typedef struct packed {
        logic [CX_FETCH_W-1:0] word;
        cx_status_e            status;
    } cx_result_t;

    typedef struct packed {
        logic       valid;
        cx_result_t res;
    } cx_out_t;

    localparam cx_out_t CX_OUT_RST = '{valid: 1'b0,
                                       res: '{word: CX_FILLER, status: CX_UNDEF}};

    typedef struct packed {
        logic [CX_FETCH_W-1:0] base;
        cx_alu_style_e         style;
    } cx_alu_entry_t;

endpackage

// File: rtl/cx_lane_pick.sv
module cx_lane_pick
    import cx_pkg::*;
(
    input  logic [CX_FETCH_W-1:0] fetch_word,
    input  logic                  hi_first,
    output logic [CX_HALF_W-1:0]  cur_hw
);

    always_comb begin
        if (hi_first) begin
            cur_hw = fetch_word[CX_FETCH_W-1:CX_HALF_W];
        end else begin
            cur_hw = fetch_word[CX_HALF_W-1:0];
        end
    end

endmodule

// File: rtl/cx_dp_expand.sv
module cx_dp_expand
    import cx_pkg::*;
(
    input  logic [CX_HALF_W-1:0] hw,
    output cx_result_t           res
);

    function automatic cx_alu_entry_t alu_entry(input logic [3:0] op);
        cx_alu_entry_t e;
        unique case (op)
            4'h0: e = '{32'hE0100000, ALU_PLAIN};
            4'h1: e = '{32'hE0300000, ALU_PLAIN};
            4'h2: e = '{32'hE1B00010, ALU_SHIFT};
            4'h3: e = '{32'hE1B00030, ALU_SHIFT};
            4'h4: e = '{32'hE1B00050, ALU_SHIFT};
            4'h5: e = '{32'hE0B00000, ALU_PLAIN};
            4'h6: e = '{32'hE0D00000, ALU_PLAIN};
            4'h7: e = '{32'hE1B00070, ALU_SHIFT};
            4'h8: e = '{32'hE1100000, ALU_PLAIN};
            4'h9: e = '{32'hE2700000, ALU_NEG};
            4'hA: e = '{32'hE1500000, ALU_PLAIN};
            4'hB: e = '{32'hE1700000, ALU_PLAIN};
            4'hC: e = '{32'hE1900000, ALU_PLAIN};
            4'hD: e = '{32'hE0100090, ALU_MUL};
            4'hE: e = '{32'hE1D00000, ALU_PLAIN};
            default: e = '{32'hE1F00000, ALU_PLAIN};
        endcase
        return e;
    endfunction

    logic [2:0]    r_lo;
    logic [2:0]    r_mid;
    logic [2:0]    r_hi;
    logic [3:0]    wide_d;
    logic [3:0]    wide_s;
    cx_alu_entry_t alu;

    always_comb begin
        r_lo   = hw[2:0];
        r_mid  = hw[5:3];
        r_hi   = hw[10:8];
        wide_d = {hw[7], hw[2:0]};
        wide_s = {hw[6], hw[5:3]};
        alu    = alu_entry(hw[9:6]);

        res.word   = '0;
        res.status = CX_OK;

        if (hw[15:13] == 3'b000 && hw[12:11] != 2'b11) begin
            // immediate shift
            res.word        = 32'hE1B00000;
            res.word[6:5]   = hw[12:11];
            res.word[11:7]  = hw[10:6];
            res.word[2:0]   = r_mid;
            res.word[14:12] = r_lo;
        end else if (hw[15:11] == 5'd3) begin
            // three-operand add/sub
            unique case (hw[10:9])
                2'd0:    res.word = 32'hE0900000;
                2'd1:    res.word = 32'hE0500000;
                2'd2:    res.word = 32'hE2900000;
                default: res.word = 32'hE2500000;
            endcase
            res.word[2:0]   = hw[8:6];
            res.word[18:16] = r_mid;
            res.word[14:12] = r_lo;
        end else if (hw[15:13] == 3'b001) begin
            // 8-bit immediate forms
            unique case (hw[12:11])
                2'd0:    res.word = 32'hE3B00000;
                2'd1:    res.word = 32'hE3500000;
                2'd2:    res.word = 32'hE2900000;
                default: res.word = 32'hE2500000;
            endcase
            res.word[7:0]   = hw[7:0];
            res.word[18:16] = r_hi;
            res.word[14:12] = r_hi;
        end else if (hw[15:11] == 5'd8 && !hw[10]) begin
            // register ALU
            res.word = alu.base;
            unique case (alu.style)
                ALU_PLAIN: begin
                    res.word[18:16] = r_lo;
                    res.word[14:12] = r_lo;
                    res.word[2:0]   = r_mid;
                end
                ALU_SHIFT: begin
                    res.word[14:12] = r_lo;
                    res.word[2:0]   = r_lo;
                    res.word[10:8]  = r_mid;
                end
                ALU_NEG: begin
                    res.word[14:12] = r_lo;
                    res.word[18:16] = r_mid;
                end
                default: begin
                    res.word[18:16] = r_lo;
                    res.word[10:8]  = r_lo;
                    res.word[2:0]   = r_mid;
                end
            endcase
        end else if (hw[15:11] == 5'd8) begin
            // wide register operations
            unique case (hw[9:6])
                4'h1, 4'h2, 4'h3: res.word = 32'hE0800000;
                4'h5, 4'h6, 4'h7: res.word = 32'hE1500000;
                4'h9, 4'hA, 4'hB: res.word = 32'hE1A00000;
                4'hC, 4'hD:       res.word = 32'hE12FFF10;
                default:          res.status = CX_UNDEF;
            endcase
            if (hw[9:8] == 2'b11) begin
                res.word[3:0] = hw[6:3];
            end else begin
                res.word[19:16] = wide_d;
                res.word[15:12] = wide_d;
                res.word[3:0]   = wide_s;
            end
        end else begin
            res.status = CX_UNDEF;
        end
    end

endmodule

// File: rtl/cx_ls_expand.sv
module cx_ls_expand
    import cx_pkg::*;
(
    input  logic [CX_HALF_W-1:0] hw,
    output cx_result_t           res
);

    logic [2:0] r_lo;
    logic [2:0] r_mid;
    logic [2:0] r_hi;

    always_comb begin
        r_lo  = hw[2:0];
        r_mid = hw[5:3];
        r_hi  = hw[10:8];

        res.word   = '0;
        res.status = CX_OK;

        casez (hw[15:11])
            5'b01001: begin
                res.word        = 32'hE59F0000;
                res.word[14:12] = r_hi;
                res.word[9:2]   = hw[7:0];
            end
            5'b0101?: begin
                unique case ({hw[9], hw[11:10]})
                    3'b000:  res.word = 32'hE7800000;
                    3'b001:  res.word = 32'hE7C00000;
                    3'b010:  res.word = 32'hE7900000;
                    3'b011:  res.word = 32'hE7D00000;
                    3'b100:  res.word = 32'hE18000B0;
                    3'b101:  res.word = 32'hE19000D0;
                    3'b110:  res.word = 32'hE19000B0;
                    default: res.word = 32'hE19000F0;
                endcase
                res.word[14:12] = r_lo;
                res.word[18:16] = r_mid;
                res.word[2:0]   = hw[8:6];
            end
            5'b011??: begin
                unique case (hw[12:11])
                    2'd0:    res.word = 32'hE5800000;
                    2'd1:    res.word = 32'hE5900000;
                    2'd2:    res.word = 32'hE5C00000;
                    default: res.word = 32'hE5D00000;
                endcase
                res.word[14:12] = r_lo;
                res.word[18:16] = r_mid;
                if (hw[12]) begin
                    res.word[4:0] = hw[10:6];
                end else begin
                    res.word[6:2] = hw[10:6];
                end
            end
            5'b1000?: begin
                res.word        = hw[11] ? 32'hE1D000B0 : 32'hE1C000B0;
                res.word[14:12] = r_lo;
                res.word[18:16] = r_mid;
                res.word[3:1]   = hw[8:6];
                res.word[9:8]   = hw[10:9];
            end
            5'b1001?: begin
                res.word        = hw[11] ? 32'hE59D0000 : 32'hE58D0000;
                res.word[14:12] = r_hi;
                res.word[9:2]   = hw[7:0];
            end
            5'b1010?: begin
                res.word        = hw[11] ? 32'hE28D0F00 : 32'hE28F0F00;
                res.word[14:12] = r_hi;
                res.word[7:0]   = hw[7:0];
            end
            5'b1011?: begin
                if (hw[11:8] == 4'h0) begin
                    res.word      = hw[7] ? 32'hE24DDF00 : 32'hE28DDF00;
                    res.word[6:0] = hw[6:0];
                end else if (hw[11:8] == 4'hE) begin
                    res.status = CX_UNDEF;
                end else begin
                    unique case ({hw[11], hw[8]})
                        2'b00:   res.word = 32'hE92D0000;
                        2'b01:   res.word = 32'hE92D4000;
                        2'b10:   res.word = 32'hE8BD0000;
                        default: res.word = 32'hE8BD8000;
                    endcase
                    res.word[7:0] = hw[7:0];
                end
            end
            5'b1100?: begin
                res.word        = hw[11] ? 32'hE8B00000 : 32'hE8A00000;
                res.word[18:16] = r_hi;
                res.word[7:0]   = hw[7:0];
            end
            default: res.status = CX_UNDEF;
        endcase
    end

endmodule

// File: rtl/cx_ctl_expand.sv
module cx_ctl_expand
    import cx_pkg::*;
(
    input  logic [CX_HALF_W-1:0] hw,
    output cx_result_t           res
);

    localparam logic [7:0] TRAP_SPECIAL = 8'h18;

    always_comb begin
        res.word   = '0;
        res.status = CX_OK;
        casez (hw[15:11])
            5'b1101?: begin
                if (hw[11:8] == 4'hF) begin
                    res.word = 32'hEF000000;
                    if (hw[7:0] == TRAP_SPECIAL) begin
                        res.word[23:16] = hw[7:0];
                    end else begin
                        res.word[7:0] = hw[7:0];
                    end
                end else if (hw[11:8] == 4'hE) begin
                    res.status = CX_UNDEF;
                end else begin
                    res.status = CX_BRANCH;
                end
            end
            5'b11101: res.status = CX_UNDEF;
            5'b11100,
            5'b1111?: res.status = CX_BRANCH;
            default:  res.status = CX_UNDEF;
        endcase
    end

endmodule

// File: rtl/cx_expand.sv
module cx_expand
    import cx_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [CX_FETCH_W-1:0] fetch_word,
    input  logic                  hi_first,
    output logic                  out_valid,
    output logic [CX_FETCH_W-1:0] out_word,
    output logic [1:0]            out_status
);

    localparam logic [CX_GRP_W-1:0] LAST_DP_GRP = 5'd8;
    localparam logic [CX_GRP_W-1:0] LAST_LS_GRP = 5'd25;

    logic [CX_HALF_W-1:0] cur_hw;
    logic [CX_GRP_W-1:0]  grp;
    cx_result_t           dp_res;
    cx_result_t           ls_res;
    cx_result_t           ctl_res;
    cx_result_t           sel_res;

    cx_lane_pick u_pick (
        .fetch_word (fetch_word),
        .hi_first   (hi_first),
        .cur_hw     (cur_hw)
    );

    cx_dp_expand u_dp (
        .hw  (cur_hw),
        .res (dp_res)
    );

    cx_ls_expand u_ls (
        .hw  (cur_hw),
        .res (ls_res)
    );

    cx_ctl_expand u_ctl (
        .hw  (cur_hw),
        .res (ctl_res)
    );

    always_comb begin
        grp = cur_hw[CX_HALF_W-1 -: CX_GRP_W];
        if (grp <= LAST_DP_GRP) begin
            sel_res = dp_res;
        end else if (grp <= LAST_LS_GRP) begin
            sel_res = ls_res;
        end else begin
            sel_res = ctl_res;
        end
        if (sel_res.status != CX_OK) begin
            sel_res.word = CX_FILLER;
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            cx_out_t out_d;
            cx_out_t out_q;

            always_comb begin
                out_d       = out_q;
                out_d.valid = in_valid;
                if (in_valid) begin
                    out_d.res = sel_res;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= CX_OUT_RST;
                end else begin
                    out_q <= out_d;
                end
            end

            assign out_valid  = out_q.valid;
            assign out_word   = out_q.res.word;
            assign out_status = out_q.res.status;
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_word   = sel_res.word;
            assign out_status = sel_res.status;
        end
    endgenerate

endmodule

// File: rtl/cx_expand_chk.sv
module cx_expand_chk
    import cx_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [CX_FETCH_W-1:0] fetch_word,
    input logic                  hi_first,
    input logic                  out_valid,
    input logic [CX_FETCH_W-1:0] out_word,
    input logic [1:0]            out_status
);

    logic [CX_HALF_W-1:0] hw_c;
    assign hw_c = hi_first ? fetch_word[CX_FETCH_W-1:CX_HALF_W] : fetch_word[CX_HALF_W-1:0];

    assert_filler_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_status != 2'b00) |-> (out_word == CX_FILLER));

    assert_status_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_status != 2'b11);

    generate
        if (OUT_REG) begin : g_seq
            assert_valid_track_R13: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_status)));

            assert_group29_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && hw_c[15:11] == 5'd29) |=> (out_status == 2'b10));

            assert_long_branch_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && hw_c[15:12] == 4'hF) |=> (out_status == 2'b01));

            assert_trap_number_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && hw_c[15:8] == 8'hDF && hw_c[7:0] != 8'h18)
                |=> (out_status == 2'b00 && out_word == {24'hEF0000, $past(hw_c[7:0])}));

            assert_shift_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && hw_c[15:13] == 3'b000 && hw_c[12:11] != 2'b11)
                |=> (out_word[31:20] == 12'hE1B && out_word[6:5] == $past(hw_c[12:11])));
        end
    endgenerate

endmodule

bind cx_expand cx_expand_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .fetch_word (fetch_word),
    .hi_first   (hi_first),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .out_status (out_status)
);

// File: tb/cx_expand_tb.sv
module cx_expand_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FILL = 32'hDEADC0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] fetch_word = 32'h0;
    logic        hi_first = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic [1:0]  out_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cx_expand u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .fetch_word (fetch_word),
        .hi_first   (hi_first),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .out_status (out_status)
    );

    // Behavioural expectation, written from the requirement text.
    function automatic void model(input logic [15:0] h, output logic [31:0] w, output logic [1:0] s);
        int x, g, a, b, c, hi8, imm, op, d4, s4;
        int st;
        logic [31:0] base;
        x = int'(h);
        g = x >> 11; a = x & 7; b = (x >> 3) & 7; c = (x >> 6) & 7;
        hi8 = (x >> 8) & 7; imm = x & 255; op = (x >> 6) & 15;
        w = 32'h0; s = 2'b00;
        if (g < 3) begin
            w = 32'hE1B00000 | (((x >> 11) & 3) << 5) | (((x >> 6) & 31) << 7) | b | (a << 12);
        end else if (g == 3) begin
            case ((x >> 9) & 3)
                0: base = 32'hE0900000; 1: base = 32'hE0500000;
                2: base = 32'hE2900000; default: base = 32'hE2500000;
            endcase
            w = base | c | (b << 16) | (a << 12);
        end else if (g < 8) begin
            case (g - 4)
                0: base = 32'hE3B00000; 1: base = 32'hE3500000;
                2: base = 32'hE2900000; default: base = 32'hE2500000;
            endcase
            w = base | imm | (hi8 << 16) | (hi8 << 12);
        end else if (g == 8 && ((x >> 10) & 1) == 0) begin
            st = 0;
            case (op)
                0: base = 32'hE0100000;  1: base = 32'hE0300000;
                2: begin base = 32'hE1B00010; st = 1; end
                3: begin base = 32'hE1B00030; st = 1; end
                4: begin base = 32'hE1B00050; st = 1; end
                5: base = 32'hE0B00000;  6: base = 32'hE0D00000;
                7: begin base = 32'hE1B00070; st = 1; end
                8: base = 32'hE1100000;
                9: begin base = 32'hE2700000; st = 2; end
                10: base = 32'hE1500000; 11: base = 32'hE1700000;
                12: base = 32'hE1900000;
                13: begin base = 32'hE0100090; st = 3; end
                14: base = 32'hE1D00000;
                default: base = 32'hE1F00000;
            endcase
            case (st)
                0: w = base | (a << 16) | (a << 12) | b;
                1: w = base | (a << 12) | a | (b << 8);
                2: w = base | (a << 12) | (b << 16);
                default: w = base | (a << 16) | (a << 8) | b;
            endcase
        end else if (g == 8) begin
            d4 = a + 8 * ((x >> 7) & 1);
            s4 = b + 8 * ((x >> 6) & 1);
            if (op >= 1 && op <= 3) w = 32'hE0800000 | (d4 << 16) | (d4 << 12) | s4;
            else if (op >= 5 && op <= 7) w = 32'hE1500000 | (d4 << 16) | (d4 << 12) | s4;
            else if (op >= 9 && op <= 11) w = 32'hE1A00000 | (d4 << 16) | (d4 << 12) | s4;
            else if (op == 12 || op == 13) w = 32'hE12FFF10 | ((x >> 3) & 15);
            else s = 2'b10;
        end else if (g == 9) begin
            w = 32'hE59F0000 | (hi8 << 12) | (imm << 2);
        end else if (g == 10 || g == 11) begin
            case (((x >> 9) & 1) * 4 + ((x >> 10) & 3))
                0: base = 32'hE7800000; 1: base = 32'hE7C00000;
                2: base = 32'hE7900000; 3: base = 32'hE7D00000;
                4: base = 32'hE18000B0; 5: base = 32'hE19000D0;
                6: base = 32'hE19000B0; default: base = 32'hE19000F0;
            endcase
            w = base | (a << 12) | (b << 16) | c;
        end else if (g >= 12 && g <= 15) begin
            case (g - 12)
                0: base = 32'hE5800000; 1: base = 32'hE5900000;
                2: base = 32'hE5C00000; default: base = 32'hE5D00000;
            endcase
            w = base | (a << 12) | (b << 16) | ((g >= 14) ? ((x >> 6) & 31) : (((x >> 6) & 31) << 2));
        end else if (g == 16 || g == 17) begin
            w = ((g == 17) ? 32'hE1D000B0 : 32'hE1C000B0) | (a << 12) | (b << 16)
                | (((((x >> 6) & 31) * 2) & 15)) | (((((x >> 6) & 31) * 2) >> 4) << 8);
        end else if (g == 18 || g == 19) begin
            w = ((g == 19) ? 32'hE59D0000 : 32'hE58D0000) | (hi8 << 12) | (imm << 2);
        end else if (g == 20 || g == 21) begin
            w = ((g == 21) ? 32'hE28D0F00 : 32'hE28F0F00) | (hi8 << 12) | imm;
        end else if (g == 22 || g == 23) begin
            if (((x >> 8) & 15) == 0) w = (((x >> 7) & 1) ? 32'hE24DDF00 : 32'hE28DDF00) | (x & 127);
            else if (((x >> 8) & 15) == 14) s = 2'b10;
            else begin
                case (((x >> 11) & 1) * 2 + ((x >> 8) & 1))
                    0: base = 32'hE92D0000; 1: base = 32'hE92D4000;
                    2: base = 32'hE8BD0000; default: base = 32'hE8BD8000;
                endcase
                w = base | imm;
            end
        end else if (g == 24 || g == 25) begin
            w = ((g == 25) ? 32'hE8B00000 : 32'hE8A00000) | (hi8 << 16) | imm;
        end else if (g == 26 || g == 27) begin
            if (((x >> 8) & 15) == 15) w = (imm == 24) ? 32'hEF180000 : (32'hEF000000 | imm);
            else if (((x >> 8) & 15) == 14) s = 2'b10;
            else s = 2'b01;
        end else if (g == 29) begin
            s = 2'b10;
        end else begin
            s = 2'b01;
        end
        if (s != 2'b00) w = FILL;
    endfunction

    task automatic check_out(input logic [31:0] exp_w, input logic [1:0] exp_s,
                             input logic exp_v, input string tag);
        n_checks++;
        if (out_word !== exp_w || out_status !== exp_s || out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s: word %h status %b valid %b, expected word %h status %b valid %b",
                     tag, out_word, out_status, out_valid, exp_w, exp_s, exp_v);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic issue(input logic [15:0] hw, input logic hi, input logic [31:0] exp_w,
                         input logic [1:0] exp_s, input string tag);
        logic [15:0] other;
        other = ~hw ^ 16'h5A3C;
        @(negedge clk);
        in_valid   = 1'b1;
        hi_first   = hi;
        fetch_word = hi ? {hw, other} : {other, hw};
        @(negedge clk);
        check_out(exp_w, exp_s, 1'b1, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 180000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] mw;
        logic [1:0]  ms;
        repeat (3) @(negedge clk);
        check_out(FILL, 2'b10, 1'b0, "R13 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_out(FILL, 2'b10, 1'b0, "R13 idle after reset");

        issue(16'h0088, 1'b0, 32'hE1B00101, 2'b00, "R2 shift imm");
        issue(16'h1C51, 1'b1, 32'hE2921001, 2'b00, "R3 add imm3");
        issue(16'h2A7F, 1'b0, 32'hE352207F, 2'b00, "R4 compare imm8");
        issue(16'h434A, 1'b1, 32'hE0120291, 2'b00, "R5 multiply style");
        issue(16'h4088, 1'b0, 32'hE1B00110, 2'b00, "R5 shift-by-register style");
        issue(16'h4248, 1'b1, 32'hE2710000, 2'b00, "R5 negate style");
        issue(16'h46C8, 1'b0, 32'hE1A88009, 2'b00, "R6 wide move");
        issue(16'h4770, 1'b1, 32'hE12FFF1E, 2'b00, "R6 register jump form");
        issue(16'h4400, 1'b0, FILL, 2'b10, "R6 undefined sub-op 0");
        issue(16'h4A05, 1'b1, 32'hE59F2014, 2'b00, "R7 pc-relative load");
        issue(16'h5888, 1'b0, 32'hE7910002, 2'b00, "R7 register-offset load");
        issue(16'h5E88, 1'b1, 32'hE19100F2, 2'b00, "R7 signed halfword load");
        issue(16'h6848, 1'b0, 32'hE5910004, 2'b00, "R8 word offset scaled");
        issue(16'h7848, 1'b1, 32'hE5D10001, 2'b00, "R8 byte offset unscaled");
        issue(16'h8A48, 1'b0, 32'hE1D101B2, 2'b00, "R8 halfword split offset");
        issue(16'h9BFF, 1'b1, 32'hE59D33FC, 2'b00, "R9 sp-relative load");
        issue(16'hA110, 1'b0, 32'hE28F1F10, 2'b00, "R9 pc address add");
        issue(16'hA910, 1'b1, 32'hE28D1F10, 2'b00, "R9 sp address add");
        issue(16'hB084, 1'b0, 32'hE24DDF04, 2'b00, "R10 sp subtract");
        issue(16'hB530, 1'b1, 32'hE92D4030, 2'b00, "R10 push with link");
        issue(16'hBD0F, 1'b0, 32'hE8BD800F, 2'b00, "R10 pop with pc");
        issue(16'hBE00, 1'b1, FILL, 2'b10, "R10 pattern E undefined");
        issue(16'hC90F, 1'b0, 32'hE8B1000F, 2'b00, "R10 multiple load");
        issue(16'hDF12, 1'b1, 32'hEF000012, 2'b00, "R11 trap number");
        issue(16'hDF18, 1'b0, 32'hEF180000, 2'b00, "R11 special trap 0x18");
        issue(16'hD005, 1'b1, FILL, 2'b01, "R12 conditional branch");
        issue(16'hDE00, 1'b0, FILL, 2'b10, "R12 condition E undefined");
        issue(16'hE000, 1'b1, FILL, 2'b01, "R12 group 28 branch");
        issue(16'hE800, 1'b0, FILL, 2'b10, "R12 group 29 undefined");
        issue(16'hF000, 1'b1, FILL, 2'b01, "R12 group 30 branch");
        issue(16'hF800, 1'b0, FILL, 2'b01, "R12 group 31 branch");

        // R1: one fetch word, both lane orders
        @(negedge clk);
        in_valid = 1'b1; fetch_word = 32'h1C512A7F; hi_first = 1'b1;
        @(negedge clk);
        check_out(32'hE2921001, 2'b00, 1'b1, "R1 upper lane first");
        hi_first = 1'b0;
        @(negedge clk);
        check_out(32'hE352207F, 2'b00, 1'b1, "R1 lower lane first");

        // R13: idle input holds the last result
        in_valid = 1'b0; fetch_word = 32'hE800E800;
        @(negedge clk);
        check_out(32'hE352207F, 2'b00, 1'b0, "R13 hold while idle");
        @(negedge clk);
        check_out(32'hE352207F, 2'b00, 1'b0, "R13 hold second idle cycle");

        // Exhaustive sweep against the behavioural model, lane alternating.
        for (int i = 0; i < 65536; i++) begin
            model(16'(i), mw, ms);
            issue(16'(i), i[0], mw, ms, "R1-sweep model compare R12");
        end

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule